// File: doc/BRIEF.md
# Randomized Iterative Crossbar Matcher

This block schedules the crossbar of an N-port input-queued switch in which every input holds one queue per output. Once per scheduling phase the caller presents an N-by-N request matrix, where bit `i*N + j` set means input `i` holds at least one cell for output `j`. The block then computes a set of input/output pairs with no port used twice. The crossbar uses that set to move cells.

Matching runs over a fixed number of rounds, one round per clock. In each round, every output that is still free picks one of the free inputs that request it. The pick is random: a pseudo-random starting point is chosen, and the first candidate from that point in circular order wins. Every free input that receives one or more offers then accepts exactly one of them, chosen by the same randomized rule. Accepted pairs are frozen, and their row and column drop out of all later rounds.

The pseudo-random values come from an internal linear-feedback shift register that advances every clock. After the last round the block raises a one-cycle completion pulse. It then holds the final match until the next accepted start.

Top module: `pim_sched`

## Requirements
- R1: Every set bit of `match_o` (bit `i*N+j` = input i paired with output j) is also set in the request matrix captured when the run was started.
- R2: `match_o` never has more than one set bit in any row (fixed input i, bits `i*N+0` to `i*N+N-1`).
- R3: `match_o` never has more than one set bit in any column (fixed output j, bits `j`, `N+j`, ... `(N-1)*N+j`).
- R4: Suppose `start_i` is sampled high at a clock edge while the block is idle. Then `busy_o` is high from that edge until exactly ITERS edges later. At that later edge `busy_o` falls and `done_o` goes high for exactly one cycle.
- R5: When ITERS is at least N, the final match is maximal. No requested pair remains whose input and output are both unmatched.
- R6: An all-zero request matrix completes with the normal timing of R4 and an all-zero match.
- R7: `start_i` and `req_i` are ignored while `busy_o` is high. The running match stays a subset of the original request, and the completion timing is unchanged.
- R8: During a run, a pair that has been matched is never removed in a later round.
- R9: When each row and each column of the request holds at most one set bit, the final match equals the request.
- R10: After reset, `match_o` is zero and `busy_o` and `done_o` are low.
- R11: While the block is idle, `match_o` holds its last value until a new start is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a run with `req_i` (taken only when idle) |
| req_i | input | N*N | Request matrix, bit i*N+j = input i wants output j |
| busy_o | output | 1 | Matching rounds in progress |
| done_o | output | 1 | One-cycle pulse when the final match is ready |
| match_o | output | N*N | Match matrix, same bit layout as `req_i` |

## Verification
The assertions assume that `req_i` matters only at an edge where `start_i` is high and the block is idle. Their subset check compares the match against a copy of the request taken at that edge, not against the live input. The maximality check is valid only because every round adds at least one pair while a free requested pair exists, so it is guarded by ITERS being at least N. The stimulus drives starts only at the negative clock edge. It deliberately changes `req_i` and pulses `start_i` in the middle of a run, to confirm that neither is captured. It mixes directed permutation, full, single-row, single-column and empty matrices with random matrices of varying density.

// File: rtl/pim_pkg.sv
package pim_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } sched_state_e;
endpackage

// File: rtl/pim_lfsr.sv
module pim_lfsr #(
  parameter int unsigned        W    = 16,
  parameter logic [W-1:0]       TAPS = 16'hB400,
  parameter logic [W-1:0]       SEED = 16'hACE1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  output logic [W-1:0] state_o
);
  logic [W-1:0] q;

  // Galois form, right shift; a nonzero seed never reaches the zero state
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= SEED;
    else         q <= (q >> 1) ^ (q[0] ? TAPS : '0);
  end

  assign state_o = q;
endmodule

// File: rtl/pim_rr_pick.sv
module pim_rr_pick #(
  parameter int unsigned N     = 4,
  parameter int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     cand_i,
  input  logic [IDX_W-1:0] seed_i,
  output logic [N-1:0]     sel_o
);
  // first set candidate at or after (seed mod N), circular
  always_comb begin
    logic found;
    int   idx;
    sel_o = '0;
    found = 1'b0;
    for (int k = 0; k < int'(N); k++) begin
      idx = (int'(seed_i) + k) % int'(N);
      if (!found && cand_i[idx]) begin
        sel_o[idx] = 1'b1;
        found      = 1'b1;
      end
    end
  end
endmodule

// File: rtl/pim_round.sv
module pim_round #(
  parameter int unsigned N      = 4,
  parameter int unsigned LFSR_W = 16,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N*N-1:0]    req_i,
  input  logic [N-1:0]      in_free_i,
  input  logic [N-1:0]      out_free_i,
  input  logic [LFSR_W-1:0] rnd_i,
  output logic [N*N-1:0]    acc_o
);
  // gnt[j*N+i]: output j offers to input i
  logic [N*N-1:0] gnt;

  for (genvar j = 0; j < N; j++) begin : g_out
    logic [N-1:0]     cand;
    logic [N-1:0]     sel;
    logic [IDX_W-1:0] seed;
    for (genvar i = 0; i < N; i++) begin : g_col
      assign cand[i] = req_i[i*N+j] & in_free_i[i] & out_free_i[j];
      assign gnt[j*N+i] = sel[i];
    end
    for (genvar b = 0; b < IDX_W; b++) begin : g_seed
      assign seed[b] = rnd_i[(j*IDX_W + b) % LFSR_W];
    end
    pim_rr_pick #(.N(N), .IDX_W(IDX_W)) i_gnt_pick (
      .cand_i(cand), .seed_i(seed), .sel_o(sel)
    );
  end

  for (genvar i = 0; i < N; i++) begin : g_in
    logic [N-1:0]     cand;
    logic [N-1:0]     sel;
    logic [IDX_W-1:0] seed;
    for (genvar j = 0; j < N; j++) begin : g_row
      assign cand[j] = gnt[j*N+i];
      assign acc_o[i*N+j] = sel[j];
    end
    for (genvar b = 0; b < IDX_W; b++) begin : g_seed
      assign seed[b] = rnd_i[(LFSR_W/2 + i*IDX_W + b) % LFSR_W];
    end
    pim_rr_pick #(.N(N), .IDX_W(IDX_W)) i_acc_pick (
      .cand_i(cand), .seed_i(seed), .sel_o(sel)
    );
  end
endmodule

// File: rtl/pim_sched.sv
module pim_sched #(
  parameter int unsigned N      = 4,
  parameter int unsigned ITERS  = 4,
  parameter int unsigned LFSR_W = 16,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1,
  localparam int unsigned CNT_W = (ITERS > 1) ? $clog2(ITERS) : 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [N*N-1:0] req_i,
  output logic           busy_o,
  output logic           done_o,
  output logic [N*N-1:0] match_o
);
  import pim_pkg::*;

  localparam logic [CNT_W-1:0] LAST = CNT_W'(ITERS - 1);

  sched_state_e     state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [N*N-1:0]   req_q, match_q, acc;
  logic [N-1:0]     in_free, out_free;
  logic [LFSR_W-1:0] rnd;
  logic             done_q;

  pim_lfsr #(.W(LFSR_W), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED)) i_lfsr (
    .clk_i, .rst_ni, .state_o(rnd)
  );

  for (genvar p = 0; p < N; p++) begin : g_free
    logic [N-1:0] row, col;
    for (genvar q = 0; q < N; q++) begin : g_bit
      assign row[q] = match_q[p*N+q];
      assign col[q] = match_q[q*N+p];
    end
    assign in_free[p]  = ~|row;
    assign out_free[p] = ~|col;
  end

  pim_round #(.N(N), .LFSR_W(LFSR_W)) i_round (
    .req_i(req_q), .in_free_i(in_free), .out_free_i(out_free),
    .rnd_i(rnd), .acc_o(acc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      req_q   <= '0;
      match_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_RUN;
          req_q   <= req_i;
          match_q <= '0;
          cnt_q   <= '0;
        end
        ST_RUN: begin
          match_q <= match_q | acc;
          if (cnt_q == LAST) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o  = (state_q == ST_RUN);
  assign done_o  = done_q;
  assign match_o = match_q;
endmodule

// File: rtl/pim_sched_chk.sv
module pim_sched_chk #(
  parameter int unsigned N     = 4,
  parameter int unsigned ITERS = 4
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           start_i,
  input logic [N*N-1:0] req_i,
  input logic           busy_o,
  input logic           done_o,
  input logic [N*N-1:0] match_o
);
  localparam int unsigned RUN_W = $clog2(ITERS + 2);

  logic [N*N-1:0]   cap_req;
  logic [RUN_W-1:0] run_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_req <= '0;
      run_cnt <= '0;
    end else if (start_i && !busy_o) begin
      cap_req <= req_i;
      run_cnt <= '0;
    end else if (busy_o) begin
      run_cnt <= run_cnt + 1'b1;
    end
  end

  function automatic logic rows_ok(logic [N*N-1:0] m);
    int c;
    rows_ok = 1'b1;
    for (int i = 0; i < int'(N); i++) begin
      c = 0;
      for (int j = 0; j < int'(N); j++) c += int'(m[i*N+j]);
      if (c > 1) rows_ok = 1'b0;
    end
  endfunction

  function automatic logic cols_ok(logic [N*N-1:0] m);
    int c;
    cols_ok = 1'b1;
    for (int j = 0; j < int'(N); j++) begin
      c = 0;
      for (int i = 0; i < int'(N); i++) c += int'(m[i*N+j]);
      if (c > 1) cols_ok = 1'b0;
    end
  endfunction

  function automatic logic maximal(logic [N*N-1:0] r, logic [N*N-1:0] m);
    logic [N-1:0] ri, co;
    ri = '0;
    co = '0;
    for (int i = 0; i < int'(N); i++)
      for (int j = 0; j < int'(N); j++)
        if (m[i*N+j]) begin ri[i] = 1'b1; co[j] = 1'b1; end
    maximal = 1'b1;
    for (int i = 0; i < int'(N); i++)
      for (int j = 0; j < int'(N); j++)
        if (r[i*N+j] && !ri[i] && !co[j]) maximal = 1'b0;
  endfunction

  a_r1_subset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_o & ~cap_req) == '0);

  a_r2_row_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rows_ok(match_o));

  a_r3_col_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cols_ok(match_o));

  a_r4_done_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (run_cnt == RUN_W'(ITERS)));

  a_r4_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r4_done_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  a_r5_maximal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && (ITERS >= N)) |-> maximal(cap_req, match_o));

  a_r7_run_length: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (run_cnt < RUN_W'(ITERS)));

  a_r8_keep_pairs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> ((match_o & $past(match_o)) == $past(match_o)));

  a_r11_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable(match_o));
endmodule

bind pim_sched pim_sched_chk #(.N(N), .ITERS(ITERS)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .req_i(req_i),
  .busy_o(busy_o), .done_o(done_o), .match_o(match_o)
);

// File: tb/test_pim_sched.sv
module test_pim_sched;
  localparam int N       = 4;
  localparam int ITERS   = 4;
  localparam int CLK_P   = 10;
  localparam int WDOG    = 100000;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic [N*N-1:0] req = '0;
  logic           busy, done;
  logic [N*N-1:0] match;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  // behavioural model
  bit             m_busy = 0;
  bit             m_done = 0;
  int             m_left = 0;
  logic [N*N-1:0] m_req  = '0;
  logic [N*N-1:0] m_hold = '0;
  bit             m_have_hold = 0;

  pim_sched #(.N(N), .ITERS(ITERS)) i_pim_sched (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .req_i(req),
    .busy_o(busy), .done_o(done), .match_o(match)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic int bits_in(logic [N*N-1:0] m, int fixed, bit by_row);
    int c = 0;
    for (int k = 0; k < N; k++) c += by_row ? int'(m[fixed*N+k]) : int'(m[k*N+fixed]);
    return c;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_left = 0;
    end else begin
      m_done = 0;
      if (!m_busy && start) begin
        m_busy = 1; m_left = ITERS; m_req = req; m_have_hold = 0;
      end else if (m_busy) begin
        m_left--;
        if (m_left == 0) begin m_busy = 0; m_done = 1; end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(busy == m_busy, "R4 busy", 64'(busy), 64'(m_busy));
      chk(done == m_done, "R4 done", 64'(done), 64'(m_done));
      chk((match & ~m_req) == '0, "R1 subset", 64'(match), 64'(m_req));
      if (m_busy || m_done) begin
        for (int k = 0; k < N; k++) begin
          chk(bits_in(match, k, 1) <= 1, "R2 row", 64'(match), 64'(k));
          chk(bits_in(match, k, 0) <= 1, "R3 col", 64'(match), 64'(k));
        end
      end
      if (m_done) begin
        bit maxi = 1;
        for (int i = 0; i < N; i++)
          for (int j = 0; j < N; j++)
            if (m_req[i*N+j] && bits_in(match, i, 1) == 0 && bits_in(match, j, 0) == 0)
              maxi = 0;
        chk(maxi, "R5 maximal", 64'(match), 64'(m_req));
        m_hold = match; m_have_hold = 1;
      end else if (!m_busy && m_have_hold) begin
        chk(match == m_hold, "R11 hold", 64'(match), 64'(m_hold));
      end
    end
  end

  task automatic run(logic [N*N-1:0] r);
    @(negedge clk);
    start = 1'b1; req = r;
    @(negedge clk);
    start = 1'b0; req = '0;
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=%0d exp<%0d", cyc, WDOG);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(match == '0, "R10 match", 64'(match), 64'(0));
    chk(busy == 1'b0, "R10 busy", 64'(busy), 64'(0));
    chk(done == 1'b0, "R10 done", 64'(done), 64'(0));
    rst_n = 1'b1;
    @(negedge clk);

    // R6: empty request
    run('0);
    chk(match == '0, "R6 empty", 64'(match), 64'(0));

    // R9: permutations match exactly
    run(16'b1000_0100_0010_0001);
    chk(match == 16'b1000_0100_0010_0001, "R9 ident", 64'(match), 64'h8421);
    run(16'b0001_0010_0100_1000);
    chk(match == 16'b0001_0010_0100_1000, "R9 anti", 64'(match), 64'h1248);
    run(16'b0000_0100_0000_1000);
    chk(match == 16'b0000_0100_0000_1000, "R9 partial", 64'(match), 64'h0408);

    // full matrix: perfect match required (R5)
    run('1);
    chk($countones(match) == N, "R5 full", 64'($countones(match)), 64'(N));
    // single row / single column: exactly one pair
    run(16'h0F00);
    chk($countones(match) == 1 && (match & ~16'h0F00) == '0, "R5 row", 64'(match), 64'h0F00);
    run(16'h2222);
    chk($countones(match) == 1 && (match & ~16'h2222) == '0, "R5 col", 64'(match), 64'h2222);

    // R7: start and req changes while busy are ignored
    @(negedge clk);
    start = 1'b1; req = 16'h00FF;
    @(negedge clk);
    req = 16'hFF00;
    repeat (2) @(negedge clk);
    start = 1'b0; req = '0;
    while (!done) @(negedge clk);
    chk((match & 16'hFF00) == '0 && $countones(match) == 2, "R7 ignore",
        64'(match), 64'h00FF);
    @(negedge clk);
    // R11: idle hold for a while
    repeat (5) @(negedge clk);

    // R8 and R1..R5 under random traffic
    for (int t = 0; t < 60; t++) begin
      logic [N*N-1:0] r = '0;
      int dens = 1 + (t % 4);
      for (int b = 0; b < N*N; b++) r[b] = ($urandom_range(0, 4) < dens);
      run(r);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule